// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Quantizer Sequencer

This block sequences a 5-bit successive-approximation quantizer built around one comparator. No bit clock paces the search. Each comparison starts when the previous one has been accepted and the charge on the capacitor array has had time to settle. A comparison ends when a completion detector sees that one of the comparator's two complementary outputs has gone high. That detector is the exclusive-or of the two rails.

A conversion begins when the quantize phase input rises. The sequencer then tries each bit from the most significant one down. A decision that the input lies at or above the trial level keeps the trial bit. After each decision the comparator is kept disabled for a programmable number of system clock cycles. During that wait the bottom plates of the decided capacitor move to reference or ground, and the capacitors not yet in play are held at common mode. When the phase falls, the result register captures the code.

A comparator that never answers is cut off by a timeout, and so is a phase that ends early. In both cases the unresolved bits are forced to zero and a sticky error flag is raised. The flag is cleared when the next conversion starts.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its idle state: `code_q` = 0, `err_flag` = 0, `cmp_en` = 0, `plate_ref` = 0 and `plate_hold` = all ones.
- R2: While `conv_phase` is low, the sequence is cleared: `cmp_en` = 0, `plate_ref` = 0 and every `plate_hold` bit = 1 (1 means the bottom plate sits at common mode).
- R3: One cycle after `conv_phase` rises, `cmp_en` is 1, `plate_ref` = 10000b and `plate_hold` = 01111b. A `plate_ref` bit of 1 selects reference and 0 selects ground.
- R4: A decision is complete when `cmp_p` XOR `cmp_n` rises. A decision with `cmp_p` = 1 keeps the trial bit and 0 clears it. `cmp_en` falls in the cycle after completion, so it stays high for exactly the comparator's latency in cycles.
- R5: Between two decisions of one conversion, `cmp_en` stays low for exactly `REDIST_CYC` cycles.
- R6: While `cmp_en` is high, `plate_hold` is 1 exactly on the bits below the lowest set bit of `plate_ref`, and those bits of `plate_ref` are 0.
- R7: Bits are resolved from the most significant bit down. When every decision completes, the final code equals the input level. Code 0 is the most negative level and 31 the most positive.
- R8: `code_q` changes only at the fall of `conv_phase`, and each conversion delivers exactly one result.
- R9: If no completion arrives within `TIMEOUT_CYC` cycles of `cmp_en` rising, `cmp_en` falls. The bit on trial and all lower bits are forced to 0 and `err_flag` is set.
- R10: If `conv_phase` falls before the last decision, the code latched into `code_q` holds only the resolved bits, with the rest 0, and `err_flag` is set.
- R11: `err_flag` stays set for the rest of the phase and is cleared one cycle after the next rise of `conv_phase`.
- R12: Both comparator rails high is not a completion. The sequencer keeps waiting and ends in the timeout of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the comparator |
| rst | input | 1 | Synchronous active-high reset |
| conv_phase | input | 1 | Quantize phase: high runs a conversion, fall latches result |
| cmp_p | input | 1 | Comparator rail: high means input at or above trial level |
| cmp_n | input | 1 | Comparator complementary rail |
| cmp_en | output | 1 | Comparator enable |
| plate_ref | output | NBITS | Per-bit bottom plate: 1 reference, 0 ground |
| plate_hold | output | NBITS | Per-bit hold at common mode |
| code_q | output | NBITS | Latched conversion result |
| err_flag | output | 1 | Sticky timeout or early-end flag |

## Verification
A wrong internal bit pointer appears on `plate_hold` and on the lowest set bit of `plate_ref` in the same cycle the comparator is enabled. A broken trial update shows up at the phase fall as a result that differs from the known input level. Faults in the wait or timeout counters appear within one decision as a wrong length of the low or high run on `cmp_en`. A missing err clear is visible a few cycles into the next phase.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sar_down_timer.sv
module sar_down_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int unsigned NBITS = 5,
  parameter int unsigned PW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start,
  input  logic             decide,
  input  logic             decision,
  input  logic             step,
  input  logic             abort,
  input  logic             in_wait,
  output logic [NBITS-1:0] trial,
  output logic [PW-1:0]    ptr,
  output logic [NBITS-1:0] below,
  output logic [NBITS-1:0] cut,
  output logic             is_last
);
  localparam logic [NBITS-1:0] MID_SCALE = {1'b1, {(NBITS-1){1'b0}}};
  localparam logic [PW-1:0]    MSB_IDX   = PW'(NBITS-1);

  logic [NBITS-1:0] trial_dec;

  // Per-bit decode of the pointer: unresolved mask, resolved mask, decision update
  always_comb begin
    for (int i = 0; i < int'(NBITS); i++) begin
      below[i] = (i < int'(ptr));
      if (in_wait) begin
        cut[i] = trial[i] & (i >= int'(ptr));
      end else begin
        cut[i] = trial[i] & (i > int'(ptr));
      end
      if (i == int'(ptr)) begin
        trial_dec[i] = decision;
      end else if (i + 1 == int'(ptr)) begin
        trial_dec[i] = 1'b1;
      end else begin
        trial_dec[i] = trial[i];
      end
    end
  end

  assign is_last = (ptr == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      trial <= '0;
      ptr   <= MSB_IDX;
    end else if (start) begin
      trial <= MID_SCALE;
      ptr   <= MSB_IDX;
    end else if (decide) begin
      trial <= trial_dec;
    end else if (step) begin
      ptr <= ptr - PW'(1);
    end else if (abort) begin
      trial <= cut;
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned NBITS       = 5,
  parameter int unsigned REDIST_CYC  = 2,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_phase,
  input  logic             cmp_p,
  input  logic             cmp_n,
  output logic             cmp_en,
  output logic [NBITS-1:0] plate_ref,
  output logic [NBITS-1:0] plate_hold,
  output logic [NBITS-1:0] code_q,
  output logic             err_flag
);
  localparam int unsigned PW  = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int unsigned WCW = (REDIST_CYC > 1) ? $clog2(REDIST_CYC + 1) : 1;
  localparam int unsigned TCW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC + 1) : 1;
  localparam logic [WCW-1:0] WAIT_LOAD = WCW'(REDIST_CYC - 1);
  localparam logic [TCW-1:0] TMO_LOAD  = TCW'(TIMEOUT_CYC - 1);

  seq_state_e state;
  logic ph_q, dn_q;
  logic cmp_done, ph_rise, ph_fall, dn_rise;
  logic in_idle, in_cmp, in_wait, in_done;
  logic start_c, decide_c, step_c, abort_c;
  logic wait_zero, tmo_zero;
  logic [NBITS-1:0] trial, below, cut;
  logic [PW-1:0]    ptr;
  logic             is_last;

  // Completion detector: exactly one rail high
  assign cmp_done = cmp_p ^ cmp_n;
  assign ph_rise  = conv_phase & ~ph_q;
  assign ph_fall  = ~conv_phase & ph_q;
  assign dn_rise  = cmp_done & ~dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      ph_q <= conv_phase;
      dn_q <= cmp_done;
    end
  end

  assign in_idle = (state == ST_IDLE);
  assign in_cmp  = (state == ST_CMP);
  assign in_wait = (state == ST_WAIT);
  assign in_done = (state == ST_DONE);

  assign start_c  = in_idle & ph_rise;
  assign decide_c = conv_phase & in_cmp & dn_rise;
  assign step_c   = conv_phase & in_wait & wait_zero;
  assign abort_c  = conv_phase & in_cmp & ~dn_rise & tmo_zero;

  sar_trial_reg #(.NBITS(NBITS), .PW(PW)) u_trial (
    .clk      (clk),
    .rst      (rst),
    .clear    (~conv_phase),
    .start    (start_c),
    .decide   (decide_c),
    .decision (cmp_p),
    .step     (step_c),
    .abort    (abort_c),
    .in_wait  (in_wait),
    .trial    (trial),
    .ptr      (ptr),
    .below    (below),
    .cut      (cut),
    .is_last  (is_last)
  );

  sar_down_timer #(.CW(WCW)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (decide_c),
    .load_val (WAIT_LOAD),
    .dec      (in_wait),
    .zero     (wait_zero)
  );

  sar_down_timer #(.CW(TCW)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .load     (start_c | step_c),
    .load_val (TMO_LOAD),
    .dec      (in_cmp),
    .zero     (tmo_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cmp_en   <= 1'b0;
      code_q   <= '0;
      err_flag <= 1'b0;
    end else begin
      if (ph_fall) begin
        code_q <= in_done ? trial : cut;
        if (!in_done) begin
          err_flag <= 1'b1;
        end
      end
      if (!conv_phase) begin
        state  <= ST_IDLE;
        cmp_en <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (ph_rise) begin
              state    <= ST_CMP;
              cmp_en   <= 1'b1;
              err_flag <= 1'b0;
            end
          end
          ST_CMP: begin
            if (dn_rise) begin
              cmp_en <= 1'b0;
              state  <= is_last ? ST_DONE : ST_WAIT;
            end else if (tmo_zero) begin
              cmp_en   <= 1'b0;
              state    <= ST_DONE;
              err_flag <= 1'b1;
            end
          end
          ST_WAIT: begin
            if (wait_zero) begin
              cmp_en <= 1'b1;
              state  <= ST_CMP;
            end
          end
          default: begin
            cmp_en <= 1'b0;
          end
        endcase
      end
    end
  end

  assign plate_ref  = trial;
  assign plate_hold = in_idle ? '1 : (in_done ? '0 : below);
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int unsigned NBITS       = 5,
  parameter int unsigned REDIST_CYC  = 2,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_phase,
  input logic             cmp_p,
  input logic             cmp_n,
  input logic             cmp_en,
  input logic [NBITS-1:0] plate_ref,
  input logic [NBITS-1:0] plate_hold,
  input logic [NBITS-1:0] code_q,
  input logic             err_flag
);
  localparam int unsigned RW = $clog2(TIMEOUT_CYC + 2);
  localparam logic [NBITS-1:0] ONE = NBITS'(1);

  logic [RW-1:0] en_run;

  always_ff @(posedge clk) begin
    if (rst || !cmp_en) begin
      en_run <= '0;
    end else if (en_run != {RW{1'b1}}) begin
      en_run <= en_run + RW'(1);
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !conv_phase |=> (!cmp_en && (plate_hold == '1) && (plate_ref == '0)));

  a_r4_en_drop: assert property (@(posedge clk) disable iff (rst)
    (conv_phase && cmp_en && (cmp_p ^ cmp_n) && !$past(cmp_p ^ cmp_n)) |=> !cmp_en);

  generate
    if (REDIST_CYC >= 2) begin : g_gap
      a_r5_wait_gap: assert property (@(posedge clk) disable iff (rst)
        (conv_phase && $fell(cmp_en)) |=> !cmp_en);
    end
  endgenerate

  a_r6_hold_shape: assert property (@(posedge clk) disable iff (rst)
    cmp_en |-> (((plate_ref & plate_hold) == '0) &&
                (((plate_hold + ONE) & plate_hold) == '0)));

  a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
    conv_phase |=> $stable(code_q));

  a_r9_tmo_bound: assert property (@(posedge clk) disable iff (rst)
    en_run <= RW'(TIMEOUT_CYC));

  a_r11_err_clear: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_phase) |=> !err_flag);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (conv_phase && $past(conv_phase) && err_flag) |=> err_flag);
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(
  .NBITS       (NBITS),
  .REDIST_CYC  (REDIST_CYC),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_phase (conv_phase),
  .cmp_p      (cmp_p),
  .cmp_n      (cmp_n),
  .cmp_en     (cmp_en),
  .plate_ref  (plate_ref),
  .plate_hold (plate_hold),
  .code_q     (code_q),
  .err_flag   (err_flag)
);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 5;
  localparam int REDIST     = 2;
  localparam int TMO        = 16;

  logic clk = 1'b0;
  logic rst;
  logic conv_phase;
  logic cmp_p, cmp_n;
  logic cmp_en;
  logic [NB-1:0] plate_ref, plate_hold, code_q;
  logic err_flag;

  int total = 0;
  int bad   = 0;
  int lvl, mode, stall_bit, cdly, ccnt;
  int last_exp = 0;
  int exp_code_q[$];
  int exp_err_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_seq_ctrl #(.NBITS(NB), .REDIST_CYC(REDIST), .TIMEOUT_CYC(TMO)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .conv_phase (conv_phase),
    .cmp_p      (cmp_p),
    .cmp_n      (cmp_n),
    .cmp_en     (cmp_en),
    .plate_ref  (plate_ref),
    .plate_hold (plate_hold),
    .code_q     (code_q),
    .err_flag   (err_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioral comparator: rails low while disabled, answer after cdly cycles
  always @(negedge clk) begin
    if (rst || !cmp_en) begin
      ccnt = 0;
      cmp_p <= 1'b0;
      cmp_n <= 1'b0;
    end else begin
      ccnt = ccnt + 1;
      if (ccnt == cdly) begin
        if (mode != 0 && $countones(plate_hold) == stall_bit) begin
          if (mode == 2) begin
            cmp_p <= 1'b1;
            cmp_n <= 1'b1;
          end
        end else begin
          cmp_p <= (lvl >= int'(plate_ref));
          cmp_n <= !(lvl >= int'(plate_ref));
        end
      end
    end
  end

  // Scoreboard monitor: one result per phase fall
  initial begin
    forever begin
      @(negedge conv_phase);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      if (exp_code_q.size() == 0) begin
        check(1'b0, "R8 unexpected result", int'(code_q), -1);
      end else begin
        int ec, ee;
        ec = exp_code_q.pop_front();
        ee = exp_err_q.pop_front();
        check(int'(code_q) == ec, "R7/R9/R10 code", int'(code_q), ec);
        check(int'(err_flag) == ee, "R9/R10 err_flag", int'(err_flag), ee);
      end
    end
  end

  // Driver: one conversion; md 0 normal, 1 no answer at bit sb, 2 both rails at bit sb
  task automatic run_conv(input int level, input int md, input int sb,
                          input int dly, input int hi);
    int ec, ee, st, hi_run, lo_run;
    bit hold_ok;
    if (md == 0) begin
      ec = level;
      ee = 0;
    end else begin
      ec = level & ~((1 << (sb + 1)) - 1);
      ee = 1;
    end
    exp_code_q.push_back(ec);
    exp_err_q.push_back(ee);
    lvl = level; mode = md; stall_bit = sb; cdly = dly;
    st = 0; hi_run = 0; lo_run = 0; hold_ok = 1'b1;
    @(negedge clk);
    conv_phase = 1'b1;
    for (int c = 0; c < hi; c++) begin
      @(negedge clk);
      if (c == 0) begin
        check(cmp_en == 1'b1, "R3 enable after rise", int'(cmp_en), 1);
        check(plate_ref == 5'b10000, "R3 mid-scale trial", int'(plate_ref), 16);
        check(plate_hold == 5'b01111, "R3 initial hold", int'(plate_hold), 15);
      end
      if (c == 4) begin
        check(int'(code_q) == last_exp, "R8 code held mid-phase", int'(code_q), last_exp);
        check(err_flag == 1'b0, "R11 err cleared by new phase", int'(err_flag), 0);
      end
      if (cmp_en) begin
        int r;
        r = int'(plate_ref);
        if (int'(plate_hold) != ((r & (-r)) - 1)) hold_ok = 1'b0;
      end
      if (st == 0 && cmp_en) hi_run++;
      else if (st == 0 && hi_run > 0) begin st = 1; lo_run = 1; end
      else if (st == 1 && !cmp_en) lo_run++;
      else if (st == 1 && cmp_en) st = 2;
    end
    check(hold_ok, "R6 hold below trial bit", int'(hold_ok), 1);
    if (md == 0) begin
      check(hi_run == dly, "R4 enable high for comparator latency", hi_run, dly);
      check(lo_run == REDIST, "R5 redistribution gap", lo_run, REDIST);
    end
    @(negedge clk);
    conv_phase = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c == 3) begin
        check(!cmp_en && plate_hold == '1 && plate_ref == '0, "R2 idle while phase low",
              int'(plate_hold), 31);
      end
    end
    last_exp = ec;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    conv_phase = 1'b0;
    lvl = 0; mode = 0; stall_bit = 0; cdly = 1;
    repeat (3) @(negedge clk);
    check(code_q == '0, "R1 reset code", int'(code_q), 0);
    check(err_flag == 1'b0, "R1 reset err", int'(err_flag), 0);
    check(cmp_en == 1'b0, "R1 reset enable", int'(cmp_en), 0);
    check(plate_hold == '1, "R1 reset hold", int'(plate_hold), 31);
    check(plate_ref == '0, "R1 reset plates", int'(plate_ref), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R7: binary search over several levels and comparator latencies
    run_conv(0,  0, 0, 1, 40);
    run_conv(31, 0, 0, 1, 40);
    run_conv(16, 0, 0, 3, 40);
    run_conv(15, 0, 0, 2, 40);
    run_conv(21, 0, 0, 1, 40);
    // R9: no answer at bit 1 -> bits 1..0 forced low
    run_conv(22, 1, 1, 1, 40);
    // R11: next conversion clears the flag
    run_conv(10, 0, 0, 3, 40);
    // R12: both rails high at bit 2 is not a completion
    run_conv(27, 2, 2, 1, 40);
    run_conv(1,  0, 0, 1, 40);
    // R10: phase ends before the first decision
    run_conv(30, 1, 4, 1, 6);
    run_conv(30, 0, 0, 2, 40);

    repeat (10) @(negedge clk);
    check(exp_code_q.size() == 0, "R8 one result per conversion", exp_code_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule